// File: doc/BRIEF.md
# Peak-Current Chopper Controller with Synchronous Rectification

This block is the digital half of a peak-current regulator for one phase of an H-bridge that drives a single-phase fan winding. A period strobe from a PWM timer turns the bridge on: the high side of one leg and the low side of the other are requested. The phase is chosen by a select input that is captured at the strobe. Current then rises in the winding until an external sense comparator reports the trip level. The trip ends the on-phase, and a fixed recirculation window follows. During that window the current decays through both low-side switches rather than through body diodes. The next strobe is accepted only after the window has run out.

Comparator edges are masked for a short blanking interval after each turn-on, so that switching spikes are rejected. A soft-start ramp limits the on-time of each period while the fan spins up. The ramp starts at a small cap, rises by a fixed step on every accepted period, and saturates at a maximum. A fault input for over-temperature or undervoltage drops every gate request in the same cycle, returns the controller to idle and restarts the ramp. Dead-time insertion, the comparator and the reference are outside this block.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is high and after it falls, with no strobe applied, all four gate requests are low. The output vector {hs_a, hs_b, ls_a, ls_b} is 4'b0000 in idle.
- R2: A strobe sampled high in idle starts the on-phase from the next cycle. With phase_sel=0 the outputs are 4'b1001 (hs_a and ls_b). With phase_sel=1 they are 4'b0110 (hs_b and ls_a). The phase captured at the strobe holds for the whole period, even if phase_sel changes.
- R3: During the first BLANK_CYC cycles of an on-phase, trip_i is ignored. A trip sampled in on-cycle j >= BLANK_CYC (counted from 0) ends the on-phase after j+1 cycles.
- R4: After the on-phase ends, the outputs are 4'b0011 (both low sides on, both high sides off) for exactly CLK_HZ/1e6*OFF_US cycles, which is 50 us at the default. The block then returns to idle (4'b0000).
- R5: A strobe or a trip during the recirculation window does not change its length. A strobe or a change of phase_sel during an on-phase does not change that on-phase.
- R6: Without a trip, the on-phase of the k-th accepted period after reset or fault (k from 0) lasts min(SS_INIT + k*SS_STEP, MAX_ON) cycles and is then followed by recirculation.
- R7: The on-time cap never exceeds MAX_ON and stays at MAX_ON once reached.
- R8: While fault_i is high, all gate requests are low in the same cycle, and strobes are not accepted. On release the block is idle, and the next period uses the SS_INIT cap.
- R9: hs_a and ls_a are never high together, hs_b and ls_b are never high together, and hs_a and hs_b are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | PWM period strobe, one cycle wide |
| phase_sel | input | 1 | Winding direction, captured at an accepted strobe |
| trip_i | input | 1 | Sense comparator, high when the peak current is reached |
| fault_i | input | 1 | Global fault (thermal or undervoltage) |
| hs_a | output | 1 | High-side gate request, leg A |
| hs_b | output | 1 | High-side gate request, leg B |
| ls_a | output | 1 | Low-side gate request, leg A |
| ls_b | output | 1 | Low-side gate request, leg B |

## Verification
The bench holds a trip from the first on-cycle and also pulses one inside the blanking interval. A design that blanked too short would cut the pulse early, and one that blanked too long would stretch the held case. It fires trips and strobes into the recirculation window and swaps phase_sel mid-period. A design that restarted its counters or re-latched the phase would show a shorter window or the wrong leg pair. The bench steps the soft-start ramp through saturation and raises fault during both the on-phase and the decay, so a design that gated fault through a register, kept the ramp level or accepted a strobe under fault would show a nonzero gate or an on-time that does not match.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ON    = 2'd1,
        ST_DECAY = 2'd2
    } chop_state_t;

    typedef struct packed {
        logic hs_a;
        logic hs_b;
        logic ls_a;
        logic ls_b;
    } gate_t;

    function automatic int unsigned off_cycles(input longint unsigned clk_hz,
                                               input int unsigned window_us);
        return int'((clk_hz / 64'd1_000_000) * window_us);
    endfunction

    function automatic gate_t gate_decode(input chop_state_t st, input logic ph);
        gate_t g;
        g = '0;
        case (st)
            ST_ON: begin
                g.hs_a = ~ph;
                g.ls_b = ~ph;
                g.hs_b = ph;
                g.ls_a = ph;
            end
            ST_DECAY: begin
                g.ls_a = 1'b1;
                g.ls_b = 1'b1;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/chop_downcnt.sv
module chop_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (en && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/chop_softstart.sv
module chop_softstart #(
    parameter int ON_W    = 16,
    parameter int SS_INIT = 64,
    parameter int SS_STEP = 64,
    parameter int MAX_ON  = 12000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            adv,
    output logic [ON_W-1:0] lim
);
    localparam logic [ON_W:0] INIT_V = (ON_W+1)'(SS_INIT);
    localparam logic [ON_W:0] STEP_V = (ON_W+1)'(SS_STEP);
    localparam logic [ON_W:0] MAX_V  = (ON_W+1)'(MAX_ON);

    logic [ON_W:0] level;
    logic [ON_W:0] level_nx;

    always_comb begin
        level_nx = level + STEP_V;
        if (level_nx > MAX_V) level_nx = MAX_V;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level <= INIT_V;
            lim   <= ON_W'(SS_INIT);
        end else if (adv) begin
            lim   <= level[ON_W-1:0];
            level <= level_nx;
        end
    end

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        lim <= ON_W'(MAX_ON)) else $error("cap above max"); // R7
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !adv && !$past(rst)) |=> $stable(lim)) else $error("cap moved"); // R6
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
    parameter longint unsigned CLK_HZ = 250_000_000,
    parameter int OFF_US    = 50,
    parameter int BLANK_CYC = 16,
    parameter int ON_W      = 16,
    parameter int SS_INIT   = 64,
    parameter int SS_STEP   = 64,
    parameter int MAX_ON    = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic period_stb,
    input  logic phase_sel,
    input  logic trip_i,
    input  logic fault_i,
    output logic hs_a,
    output logic hs_b,
    output logic ls_a,
    output logic ls_b
);
    import chop_pkg::*;

    localparam int unsigned OFF_CYC = off_cycles(CLK_HZ, OFF_US);
    localparam int          CNT_W   = $clog2(OFF_CYC + 1);

    chop_state_t     st;
    logic            ph_q;
    logic [ON_W-1:0] on_cnt;
    logic [ON_W-1:0] lim;
    logic            start, blank_done, cap_hit, end_on, dec_zero, end_dec;
    gate_t           g;

    assign start      = (st == ST_IDLE) && period_stb && !fault_i;
    assign blank_done = on_cnt >= ON_W'(BLANK_CYC);
    assign cap_hit    = on_cnt == (lim - ON_W'(1));
    assign end_on     = (st == ST_ON) && ((trip_i && blank_done) || cap_hit);
    assign end_dec    = (st == ST_DECAY) && dec_zero;

    chop_softstart #(
        .ON_W(ON_W), .SS_INIT(SS_INIT), .SS_STEP(SS_STEP), .MAX_ON(MAX_ON)
    ) u_ss (
        .clk(clk), .rst(rst), .clr(fault_i), .adv(start), .lim(lim)
    );

    chop_downcnt #(.W(CNT_W)) u_decay (
        .clk(clk), .rst(rst),
        .load(end_on), .load_val(CNT_W'(OFF_CYC - 1)),
        .en(st == ST_DECAY), .zero(dec_zero)
    );

    always_ff @(posedge clk) begin
        if (rst || fault_i) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  if (start)   st <= ST_ON;
                ST_ON:    if (end_on)  st <= ST_DECAY;
                ST_DECAY: if (end_dec) st <= ST_IDLE;
                default:               st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= 1'b0;
            on_cnt <= '0;
        end else begin
            if (start) ph_q <= phase_sel;
            if (start)             on_cnt <= '0;
            else if (st == ST_ON)  on_cnt <= on_cnt + 1'b1;
        end
    end

    always_comb begin
        g = gate_decode(st, ph_q);
        if (fault_i) g = '0;
    end

    assign hs_a = g.hs_a;
    assign hs_b = g.hs_b;
    assign ls_a = g.ls_a;
    assign ls_b = g.ls_b;

    AST_START_ON: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && period_stb && !fault_i) |=> (st == ST_ON || fault_i)) else $error("no turn-on"); // R2
    AST_BLANK_MASK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ON && on_cnt < ON_W'(BLANK_CYC) && !cap_hit && !fault_i) |=> (st == ST_ON || fault_i)) else $error("blank broken"); // R3
    AST_DECAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECAY && !dec_zero && !fault_i) |=> (st == ST_DECAY || fault_i)) else $error("decay cut"); // R5
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        fault_i |-> !(hs_a || hs_b || ls_a || ls_b)) else $error("gate under fault"); // R8
    AST_LEG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((hs_a && ls_a) || (hs_b && ls_b) || (hs_a && hs_b))) else $error("shoot-through"); // R9
endmodule

// File: tb/chop_ctrl_bench.sv
module chop_ctrl_bench;
    localparam int BLANK = 3;
    localparam int SI    = 5;
    localparam int SS    = 5;
    localparam int MX    = 20;
    localparam int OFFC  = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic period_stb = 1'b0, phase_sel = 1'b0, trip_i = 1'b0, fault_i = 1'b0;
    logic hs_a, hs_b, ls_a, ls_b;
    int vectors = 0, miscompares = 0, cycles = 0;

    always #2 clk = ~clk;

    chop_ctrl #(
        .CLK_HZ(1_000_000), .OFF_US(50), .BLANK_CYC(BLANK), .ON_W(8),
        .SS_INIT(SI), .SS_STEP(SS), .MAX_ON(MX)
    ) u_chop_ctrl (
        .clk(clk), .rst(rst), .period_stb(period_stb), .phase_sel(phase_sel),
        .trip_i(trip_i), .fault_i(fault_i),
        .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a), .ls_b(ls_b)
    );

    function automatic logic [3:0] gates();
        return {hs_a, hs_b, ls_a, ls_b};
    endfunction

    function automatic int cap_of(input int k);
        int c;
        c = SI + k * SS;
        return (c > MX) ? MX : c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: no trip, 1: single trip pulse at on-cycle tidx, 2: trip held from cycle 0
    task automatic run_period(input logic ph, input int mode, input int tidx,
                              input bit noise, input int exp_on, input string req);
        logic [3:0] onp;
        int on_len, dec_len;
        onp = ph ? 4'b0110 : 4'b1001;
        @(negedge clk); period_stb = 1'b1; phase_sel = ph;
        @(negedge clk); period_stb = 1'b0;
        chk({req, " R2 first on-cycle gates"}, int'(gates()), int'(onp));
        on_len = 0;
        while (gates() == onp && on_len < 300) begin
            trip_i = (mode == 2) || (mode == 1 && on_len == tidx);
            if (noise) begin
                period_stb = 1'b1;
                phase_sel  = ~ph;
            end
            on_len++;
            @(negedge clk);
        end
        trip_i = 1'b0; period_stb = 1'b0; phase_sel = ph;
        chk({req, " on-time"}, on_len, exp_on);
        chk({req, " R4 decay gates"}, int'(gates()), 3);
        dec_len = 0;
        while (gates() == 4'b0011 && dec_len < 300) begin
            if (noise) begin
                trip_i     = 1'b1;
                period_stb = dec_len[0];
            end
            dec_len++;
            @(negedge clk);
        end
        trip_i = 1'b0; period_stb = 1'b0;
        chk({req, noise ? " R5 decay length" : " R4 decay length"}, dec_len, OFFC);
        chk({req, " R4 idle after decay"}, int'(gates()), 0);
    endtask

    task automatic t_reset();
        chk("R1 gates in reset", int'(gates()), 0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 gates idle after reset", int'(gates()), 0);
    endtask

    task automatic t_fault_on();
        @(negedge clk); period_stb = 1'b1; phase_sel = 1'b0;
        @(negedge clk); period_stb = 1'b0;
        @(negedge clk);
        fault_i = 1'b1; #1;
        chk("R8 fault in on-phase drops gates", int'(gates()), 0);
        @(negedge clk); period_stb = 1'b1;
        @(negedge clk); period_stb = 1'b0; fault_i = 1'b0; #1;
        chk("R8 strobe under fault ignored", int'(gates()), 0);
        @(negedge clk);
        chk("R8 idle after fault release", int'(gates()), 0);
    endtask

    task automatic t_fault_decay();
        @(negedge clk); period_stb = 1'b1; phase_sel = 1'b0;
        @(negedge clk); period_stb = 1'b0;
        repeat (cap_of(1) + 3) @(negedge clk);
        chk("R8 in decay before fault", int'(gates()), 3);
        fault_i = 1'b1; #1;
        chk("R8 fault in decay drops gates", int'(gates()), 0);
        @(negedge clk); fault_i = 1'b0;
        @(negedge clk);
        chk("R8 idle after decay fault", int'(gates()), 0);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        run_period(1'b0, 0, 0, 1'b0, cap_of(0), "R6 k0 ph0");
        run_period(1'b1, 1, 1, 1'b0, cap_of(1), "R3 blanked pulse");
        run_period(1'b0, 2, 0, 1'b0, BLANK + 1, "R3 held trip");
        run_period(1'b1, 1, 6, 1'b0, 7, "R3 late trip");
        run_period(1'b0, 0, 0, 1'b1, cap_of(4), "R5 R7 noise sat");
        run_period(1'b1, 0, 0, 1'b0, MX, "R7 held at max");
        t_fault_on();
        run_period(1'b1, 0, 0, 1'b0, SI, "R8 ramp restart");
        t_fault_decay();
        run_period(1'b0, 0, 0, 1'b0, SI, "R8 ramp restart2");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule